// File: doc/BRIEF.md
# Vector Loop Context Register

This block holds the 64-bit context word of a vector loop: the maximum and current vector length, the source and destination element steps, the two subvector steps, five 2-bit shape selectors with their five enable bits, two loop-order inversion bits, a parallelism hint, a persistence bit for the re-mapping state and a vertical-first mode bit. Bits are numbered MSB-0: bit 0 is the most significant bit of the word.

Three commands act on it. A full-word write replaces the whole register after range checks, clamping the length or rejecting the write with a trap pulse. A length command sets the current length to the smaller of a requested length and the maximum length, optionally loading a new maximum first, and clears the persistence bit when either length changes. A swap command exchanges the register with a link copy, for a branch that saves and restores the loop context in the same cycle as the return address.

Top module: `svs_state_reg`

## Requirements
- R1: After reset the word holds maximum length 1 and current length 1 with every other bit 0; the link copy holds the same word.
- R2: A legal full-word write reads back on `state_o` with MSB-0 layout: maximum length at MSB-0 bits 0:6 (`state_o[63:57]`), current length 7:13 (`[56:50]`), source step 14:20 (`[49:43]`), destination step 21:27 (`[42:36]`), and the other fields in `[35:0]`; `mvl_o`, `vl_o`, `srcstep_o`, `dststep_o`, `persist_o` (bit 62, `[1]`) and `vfirst_o` (bit 63, `[0]`) decode those positions.
- R3: The reserved MSB-0 bits 47:52 (`state_o[16:11]`) always read zero; writes to them are dropped.
- R4: A full-word write whose current length exceeds its maximum length, both otherwise legal, stores the current length equal to the maximum length.
- R5: A full-word write with maximum length 0 or above 64, current length above 64, or a source or destination step of 64 or more is rejected: the register keeps its value and `trap_o` is high for one cycle.
- R6: A length command sets the current length to min(`sv_len_i`, maximum length), where the maximum is `sv_mvl_i` when `sv_mvl_we_i` is high and the stored maximum otherwise; all other fields except the persistence bit stay unchanged.
- R7: A length command with `sv_mvl_we_i` high and `sv_mvl_i` equal to 0 or above 64 is rejected: no change and a one-cycle `trap_o`.
- R8: A length command clears the persistence bit when it changes the current or maximum length and keeps it otherwise.
- R9: A swap exchanges the register and the link copy in one cycle.
- R10: When commands coincide, swap wins over full-word write, which wins over the length command; the losers have no effect and cannot trap.
- R11: Results and `trap_o` appear one clock after the request edge; with no command the register, the link copy and `trap_o` stay quiet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| mt_we_i | input | 1 | Full-word write request |
| mt_data_i | input | 64 | Full-word write data, MSB-0 layout |
| sv_valid_i | input | 1 | Length command request |
| sv_len_i | input | REQ_W | Requested length |
| sv_mvl_we_i | input | 1 | Length command also loads a new maximum |
| sv_mvl_i | input | REQ_W | New maximum length |
| swap_i | input | 1 | Exchange register and link copy |
| state_o | output | 64 | Register word |
| link_o | output | 64 | Link copy word |
| mvl_o | output | 7 | Maximum length field |
| vl_o | output | 7 | Current length field |
| srcstep_o | output | 7 | Source step field |
| dststep_o | output | 7 | Destination step field |
| persist_o | output | 1 | Persistence bit |
| vfirst_o | output | 1 | Vertical-first mode bit |
| trap_o | output | 1 | Illegal-write pulse |

## Verification
Every command lands in the register at the rising edge where it is sampled, and the trap flag is registered at that same edge, so both the new word and the trap are due exactly one clock after the request. The bench drives each request on a falling edge, drops it on the next falling edge and compares the outputs right there, half a cycle after the updating edge and before any later command. Sweeps of lengths and maximums on both sides of the legal range, step values around 64 and command overlaps are compared against an arithmetic model held in the bench.

// File: rtl/svs_pkg.sv
package svs_pkg;
  localparam int FW = 7;   // length and step field width
  localparam int SW = 2;   // selector / substep width
  localparam int WW = 64;  // register width

  // Declared from MSB-0 bit 0 downwards: first member is the top bits.
  typedef struct packed {
    logic [FW-1:0] maxvl;
    logic [FW-1:0] vl;
    logic [FW-1:0] srcstep;
    logic [FW-1:0] dststep;
    logic [SW-1:0] dsubstep;
    logic [SW-1:0] ssubstep;
    logic [SW-1:0] sel_ra;
    logic [SW-1:0] sel_rb;
    logic [SW-1:0] sel_rc;
    logic [SW-1:0] sel_rt;
    logic [SW-1:0] sel_ea;
    logic [4:0]    remap_en;
    logic [5:0]    rsvd;
    logic          pack;
    logic          unpack;
    logic [FW-1:0] hphint;
    logic          persist;
    logic          vfirst;
  } svs_word_t;

  function automatic svs_word_t svs_reset_word();
    svs_word_t w;
    w       = '0;
    w.maxvl = FW'(1);
    w.vl    = FW'(1);
    return w;
  endfunction
endpackage

// File: rtl/svs_mt_check.sv
module svs_mt_check
  import svs_pkg::*;
#(
  parameter int MAX_LEN = 64
) (
  input  svs_word_t wr_word_i,
  output logic      legal_o,
  output svs_word_t fixed_o
);
  localparam logic [FW-1:0] LIM = FW'(MAX_LEN);

  logic mvl_ok, vl_ok, steps_ok;

  always_comb begin
    mvl_ok   = (wr_word_i.maxvl != '0) && (wr_word_i.maxvl <= LIM);
    vl_ok    = (wr_word_i.vl <= LIM);
    steps_ok = (wr_word_i.srcstep < LIM) && (wr_word_i.dststep < LIM);
    legal_o  = mvl_ok && vl_ok && steps_ok;

    fixed_o      = wr_word_i;
    fixed_o.rsvd = '0;
    if (wr_word_i.vl > wr_word_i.maxvl) begin
      fixed_o.vl = wr_word_i.maxvl;
    end
  end
endmodule

// File: rtl/svs_setvl_calc.sv
module svs_setvl_calc
  import svs_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int REQ_W   = 8
) (
  input  svs_word_t        cur_i,
  input  logic [REQ_W-1:0] req_len_i,
  input  logic             mvl_we_i,
  input  logic [REQ_W-1:0] mvl_i,
  output logic             legal_o,
  output svs_word_t        next_o
);
  localparam logic [REQ_W-1:0] LIM = REQ_W'(MAX_LEN);

  logic [REQ_W-1:0] mvl_sel, vl_sel;
  logic             changed;

  always_comb begin
    mvl_sel = mvl_we_i ? mvl_i : REQ_W'(cur_i.maxvl);
    legal_o = !mvl_we_i || ((mvl_i != '0) && (mvl_i <= LIM));
    vl_sel  = (req_len_i < mvl_sel) ? req_len_i : mvl_sel;
    changed = (FW'(vl_sel) != cur_i.vl) || (FW'(mvl_sel) != cur_i.maxvl);

    next_o         = cur_i;
    next_o.maxvl   = FW'(mvl_sel);
    next_o.vl      = FW'(vl_sel);
    next_o.persist = cur_i.persist & ~changed;
  end
endmodule

// File: rtl/svs_state_reg.sv
module svs_state_reg
  import svs_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int REQ_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mt_we_i,
  input  logic [63:0]      mt_data_i,
  input  logic             sv_valid_i,
  input  logic [REQ_W-1:0] sv_len_i,
  input  logic             sv_mvl_we_i,
  input  logic [REQ_W-1:0] sv_mvl_i,
  input  logic             swap_i,
  output logic [63:0]      state_o,
  output logic [63:0]      link_o,
  output logic [6:0]       mvl_o,
  output logic [6:0]       vl_o,
  output logic [6:0]       srcstep_o,
  output logic [6:0]       dststep_o,
  output logic             persist_o,
  output logic             vfirst_o,
  output logic             trap_o
);
  svs_word_t state_q, state_d, link_q, link_d;
  svs_word_t mt_fixed, sv_next;
  logic      mt_legal, sv_legal;
  logic      trap_q, trap_d;
  logic      state_en, link_en;

  svs_mt_check #(.MAX_LEN(MAX_LEN)) u_mt_check (
    .wr_word_i (svs_word_t'(mt_data_i)),
    .legal_o   (mt_legal),
    .fixed_o   (mt_fixed)
  );

  svs_setvl_calc #(.MAX_LEN(MAX_LEN), .REQ_W(REQ_W)) u_setvl (
    .cur_i     (state_q),
    .req_len_i (sv_len_i),
    .mvl_we_i  (sv_mvl_we_i),
    .mvl_i     (sv_mvl_i),
    .legal_o   (sv_legal),
    .next_o    (sv_next)
  );

  // Next state: swap > full-word write > length command.
  always_comb begin
    state_d  = state_q;
    link_d   = link_q;
    state_en = 1'b0;
    link_en  = 1'b0;
    trap_d   = 1'b0;
    if (swap_i) begin
      state_d  = link_q;
      link_d   = state_q;
      state_en = 1'b1;
      link_en  = 1'b1;
    end else if (mt_we_i) begin
      state_d  = mt_fixed;
      state_en = mt_legal;
      trap_d   = !mt_legal;
    end else if (sv_valid_i) begin
      state_d  = sv_next;
      state_en = sv_legal;
      trap_d   = !sv_legal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= svs_reset_word();
      link_q  <= svs_reset_word();
      trap_q  <= 1'b0;
    end else begin
      if (state_en) state_q <= state_d;
      if (link_en)  link_q  <= link_d;
      trap_q <= trap_d;
    end
  end

  assign state_o   = state_q;
  assign link_o    = link_q;
  assign mvl_o     = state_q.maxvl;
  assign vl_o      = state_q.vl;
  assign srcstep_o = state_q.srcstep;
  assign dststep_o = state_q.dststep;
  assign persist_o = state_q.persist;
  assign vfirst_o  = state_q.vfirst;
  assign trap_o    = trap_q;
endmodule

// File: rtl/svs_state_chk.sv
module svs_state_chk #(
  parameter int MAX_LEN = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mt_we_i,
  input logic        sv_valid_i,
  input logic        swap_i,
  input logic [63:0] state_o,
  input logic [63:0] link_o,
  input logic        trap_o
);
  localparam logic [6:0] LIM = 7'(MAX_LEN);

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o[16:11] == 6'd0);

  // R5
  mvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o[63:57] != 7'd0) && (state_o[63:57] <= LIM));

  // R4
  vl_within_mvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o[56:50] <= state_o[63:57]);

  // R5
  trap_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $stable(state_o));

  // R7
  trap_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> $past(mt_we_i || sv_valid_i));

  // R9
  swap_exchange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_i |=> (state_o == $past(link_o)) && (link_o == $past(state_o)) && !trap_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(swap_i || mt_we_i || sv_valid_i) |=> $stable(state_o) && $stable(link_o) && !trap_o);
endmodule

bind svs_state_reg svs_state_chk #(.MAX_LEN(MAX_LEN)) u_state_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mt_we_i    (mt_we_i),
  .sv_valid_i (sv_valid_i),
  .swap_i     (swap_i),
  .state_o    (state_o),
  .link_o     (link_o),
  .trap_o     (trap_o)
);

// File: tb/test_svs_state_reg.sv
module test_svs_state_reg;
  localparam int CLK_PERIOD = 10;
  localparam int REQ_W      = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             mt_we_i;
  logic [63:0]      mt_data_i;
  logic             sv_valid_i;
  logic [REQ_W-1:0] sv_len_i;
  logic             sv_mvl_we_i;
  logic [REQ_W-1:0] sv_mvl_i;
  logic             swap_i;
  logic [63:0]      state_o, link_o;
  logic [6:0]       mvl_o, vl_o, srcstep_o, dststep_o;
  logic             persist_o, vfirst_o, trap_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic [63:0] exp_state, exp_link;
  localparam logic [63:0] RST_WORD = {7'd1, 7'd1, 50'd0};
  localparam logic [63:0] RSVD_MASK = 64'h3F << 11;

  always #(CLK_PERIOD/2) clk = ~clk;

  svs_state_reg #(.MAX_LEN(64), .REQ_W(REQ_W)) i_svs_state_reg (
    .clk(clk), .rst_n(rst_n), .mt_we_i(mt_we_i), .mt_data_i(mt_data_i),
    .sv_valid_i(sv_valid_i), .sv_len_i(sv_len_i), .sv_mvl_we_i(sv_mvl_we_i),
    .sv_mvl_i(sv_mvl_i), .swap_i(swap_i), .state_o(state_o), .link_o(link_o),
    .mvl_o(mvl_o), .vl_o(vl_o), .srcstep_o(srcstep_o), .dststep_o(dststep_o),
    .persist_o(persist_o), .vfirst_o(vfirst_o), .trap_o(trap_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input int mvl, input int vl, input int src,
                                     input int dst, input logic [35:0] low);
    return {7'(mvl), 7'(vl), 7'(src), 7'(dst), low};
  endfunction

  task automatic idle_inputs();
    mt_we_i = 0; mt_data_i = '0; sv_valid_i = 0; sv_len_i = '0;
    sv_mvl_we_i = 0; sv_mvl_i = '0; swap_i = 0;
  endtask

  // Request driven on a falling edge, result checked one falling edge later.
  task automatic step_and_check(input string tag, input bit exp_trap);
    @(negedge clk);
    idle_inputs();
    check({tag, " state"}, state_o, exp_state);
    check({tag, " link"}, link_o, exp_link);
    check({tag, " trap"}, {63'd0, trap_o}, {63'd0, exp_trap});
  endtask

  task automatic do_mt(input string tag, input logic [63:0] w);
    int m, v, s, d;
    bit ok;
    m = int'(w[63:57]); v = int'(w[56:50]); s = int'(w[49:43]); d = int'(w[42:36]);
    ok = (m >= 1) && (m <= 64) && (v <= 64) && (s < 64) && (d < 64);
    mt_we_i = 1; mt_data_i = w;
    if (ok) begin
      exp_state = w & ~RSVD_MASK;
      if (v > m) exp_state[56:50] = 7'(m);
    end
    step_and_check(tag, !ok);
  endtask

  task automatic do_sv(input string tag, input int len, input bit mwe, input int mvl);
    int cm, cv, nm, nv;
    bit ok;
    cm = int'(exp_state[63:57]); cv = int'(exp_state[56:50]);
    ok = !mwe || ((mvl >= 1) && (mvl <= 64));
    nm = mwe ? mvl : cm;
    nv = (len < nm) ? len : nm;
    sv_valid_i = 1; sv_len_i = REQ_W'(len); sv_mvl_we_i = mwe; sv_mvl_i = REQ_W'(mvl);
    if (ok) begin
      exp_state[63:57] = 7'(nm);
      exp_state[56:50] = 7'(nv);
      if (nm != cm || nv != cv) exp_state[1] = 1'b0;
    end
    step_and_check(tag, !ok);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [63:0] tmp;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    exp_state = RST_WORD; exp_link = RST_WORD;
    // R1 reset value
    check("R1 reset state", state_o, RST_WORD);
    check("R1 reset link", link_o, RST_WORD);
    check("R1 reset trap", {63'd0, trap_o}, 64'd0);

    // R2 field decode and layout
    do_mt("R2 write", mk(40, 17, 5, 63, 36'hF_FFFF_FFFF));
    check("R2 mvl_o", {57'd0, mvl_o}, 64'd40);
    check("R2 vl_o", {57'd0, vl_o}, 64'd17);
    check("R2 srcstep_o", {57'd0, srcstep_o}, 64'd5);
    check("R2 dststep_o", {57'd0, dststep_o}, 64'd63);
    check("R2 persist_o", {63'd0, persist_o}, 64'd1);
    check("R2 vfirst_o", {63'd0, vfirst_o}, 64'd1);
    // R3 reserved bits dropped
    check("R3 reserved", state_o & RSVD_MASK, 64'd0);

    // R4 R5 sweep of length pairs on a full-word write
    for (int m = 0; m <= 70; m++) begin
      for (int v = 0; v <= 70; v += 3) begin
        do_mt("R4/R5 len sweep", mk(m, v, m % 64, v % 64, {m[17:0], v[17:0]}));
      end
    end
    // R5 step boundaries
    for (int s = 60; s <= 70; s++) begin
      do_mt("R5 src step", mk(64, 64, s, 0, 36'h123456789));
      do_mt("R5 dst step", mk(64, 64, 0, s, 36'h0ABCDEF01));
    end

    // R6 R7 R8 length command sweep from a fixed base
    for (int nm = 0; nm <= 70; nm++) begin
      for (int rl = 0; rl <= 70; rl += 2) begin
        do_mt("R8 base", mk(32, 16, 3, 4, 36'h000000003));
        do_sv("R6/R7/R8 new max", rl, 1'b1, nm);
      end
    end
    for (int rl = 0; rl <= 255; rl += 5) begin
      do_mt("R8 base", mk(48, 20, 7, 9, 36'h000000002));
      do_sv("R6/R8 keep max", rl, 1'b0, 0);
    end
    // R8 unchanged lengths keep persistence
    do_mt("R8 base", mk(10, 10, 0, 0, 36'h000000002));
    do_sv("R8 same lengths", 200, 1'b1, 10);
    check("R8 persist kept", {63'd0, persist_o}, 64'd1);

    // R9 swap
    do_mt("R9 prep", mk(20, 5, 1, 2, 36'h5A5A0A5A5));
    swap_i = 1;
    tmp = exp_state; exp_state = exp_link; exp_link = tmp;
    step_and_check("R9 swap", 1'b0);
    swap_i = 1;
    tmp = exp_state; exp_state = exp_link; exp_link = tmp;
    step_and_check("R9 swap back", 1'b0);

    // R10 priorities
    swap_i = 1; mt_we_i = 1; mt_data_i = mk(0, 0, 0, 0, 36'd0);
    tmp = exp_state; exp_state = exp_link; exp_link = tmp;
    step_and_check("R10 swap over write", 1'b0);
    mt_we_i = 1; mt_data_i = mk(50, 30, 0, 0, 36'd0);
    sv_valid_i = 1; sv_len_i = 8'd2; sv_mvl_we_i = 1; sv_mvl_i = 8'd0;
    exp_state = mk(50, 30, 0, 0, 36'd0);
    step_and_check("R10 write over length cmd", 1'b0);

    // R11 idle cycles keep everything
    step_and_check("R11 idle", 1'b0);
    step_and_check("R11 idle again", 1'b0);

    done = 1;
    finish_run();
  end
endmodule